// File: doc/BRIEF.md
# Frame-Synchronous TDM Serial Port

The block sits between a 2048 kbit/s time-division link and three 32-byte buffers held outside it. Two transmit buffers are read one byte per timeslot and shifted out on two serial lines. One serial input line is shifted in and written back one byte per timeslot into a receive buffer. The block runs from the link clock: two clock cycles per bit, eight bits per channel, 32 channels per frame, 512 cycles in all. An active-low frame pulse aligns it. Until that pulse first arrives, the block holds both serial lines high and writes nothing.

A channel-mapping input selects how buffer locations map to timeslots. In the 32-slot map, location and timeslot are the same number. In the 24-slot map, every fourth timeslot is an idle slot that carries all ones, and the remaining slots use locations 0 to 23 in order. A 4-bit configuration word selects two things. Its low two bits pick a loopback routing among the serial input, transmit buffer 0, output 0 and the receive path. Its high two bits pick what output 1 carries. The choices are transmit buffer 1, the input delayed by one frame, or an XOR compare built from the live input, buffer 1 and the delayed input.

Top module: `tdm_serial_port`

## Requirements
- R1: From reset until the first frame pulse is detected, `txd0` and `txd1` are 1 and `rx_we` stays 0, whatever `rxd` and `cfg` do.
- R2: A frame pulse is detected at a rising edge where `fp_n` is 0 after being 1 at the edge before. The next cycle is cycle 0 of a frame. Bit n (7 down to 0) of channel c occupies cycles 16c+2(7-n) and 16c+2(7-n)+1, so the most significant bit goes first. A pulse in the middle of a frame restarts the count at cycle 0.
- R3: With `ch24`=0, channel c is sent from buffer location c and received into location c.
- R4: With `ch24`=1, channels 0, 4, 8, …, 28 send 0xFF on both transmit streams. Any other channel c uses location c - floor(c/4) - 1, which gives locations 0 to 23 in channel order.
- R5: With `ch24`=1, bytes arriving in the idle channels are not written. Locations 24 to 31 of the receive buffer are never written.
- R6: The byte received in a channel is written with one `rx_we` pulse during the last cycle of that channel (cycle 16c+15). Each bit is sampled in the second cycle of its cell, and the first bit received becomes bit 7 of the byte.
- R7: `cfg[1:0]` selects the loopback. 00 is normal operation. 01 sends `rxd` to `txd0` and still receives `rxd`. 10 sends buffer 0 to `txd0` and into the receive path, and `rxd` is ignored. 11 receives buffer 0 and sends `rxd` to `txd0`.
- R8: When `cfg[3:2]`=00, `txd1` carries the buffer 1 stream. When it is 10, `txd1` carries `rxd` XOR the buffer 1 stream.
- R9: When `cfg[3:2]`=01, `txd1` carries, in each channel, the raw `rxd` byte of the same channel in the previous frame, in both channel maps. The delay store holds all ones after reset.
- R10: When `cfg[3:2]`=11, `txd1` carries the one-frame-delayed input XOR the live `rxd`.
- R11: The block shows the buffer location for the next channel on `tx_addr` during the last cycle of the current channel. It takes `tx0_data` and `tx1_data` at the edge that starts that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, two cycles per bit |
| rst | input | 1 | Synchronous active-high reset |
| fp_n | input | 1 | Active-low frame pulse |
| rxd | input | 1 | Serial input stream |
| cfg | input | 4 | [1:0] loopback select, [3:2] output-1 source |
| ch24 | input | 1 | 1 selects the 24-slot map, 0 the 32-slot map |
| tx_addr | output | 5 | Location read from both transmit buffers |
| tx0_data | input | 8 | Byte of transmit buffer 0 at tx_addr |
| tx1_data | input | 8 | Byte of transmit buffer 1 at tx_addr |
| txd0 | output | 1 | Serial output 0 |
| txd1 | output | 1 | Serial output 1 |
| rx_we | output | 1 | Receive buffer write strobe |
| rx_addr | output | 5 | Receive buffer write location |
| rx_wdata | output | 8 | Receive buffer write byte |

## Verification
Each frame uses different byte patterns for the input and both buffers, so a swapped source, a wrong bit order or a channel shifted by one shows up as a bit mismatch on a named stream. The loopback codes are tried with an input that differs from buffer 0, so an input that leaks into the receive path or onto output 0 is caught. The delayed modes run after a frame with a known input, which tells a one-frame delay apart from a pass-through. A 24-slot frame preloads the receive buffer with a marker value, which exposes writes from idle slots and a misplaced location. A frame pulse that arrives in the middle of a frame checks that the count restarts.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    localparam int CH_W    = 5;
    localparam int BYTE_W  = 8;
    localparam int BIT_W   = $clog2(BYTE_W);
    localparam int SUB_W   = BIT_W + 1;
    localparam int CYC_W   = CH_W + SUB_W;
    localparam int NUM_CH  = 1 << CH_W;

    typedef enum logic [1:0] {
        LB_NONE      = 2'b00,
        LB_IN_TO_OUT = 2'b01,
        LB_TX_TO_RX  = 2'b10,
        LB_CROSS     = 2'b11
    } loop_e;

    typedef enum logic [1:0] {
        O1_BUF      = 2'b00,
        O1_DELAY    = 2'b01,
        O1_XOR_BUF  = 2'b10,
        O1_XOR_DLY  = 2'b11
    } out1_e;

    typedef struct packed {
        logic            idle;
        logic [CH_W-1:0] loc;
    } slot_map_t;

    // Timeslot to buffer location. In the 24-slot map every fourth slot idles.
    function automatic slot_map_t map_slot(input logic [CH_W-1:0] ch, input logic short_map);
        slot_map_t m;
        logic [CH_W-1:0] grp;
        logic [CH_W-1:0] sub;
        grp    = ch >> 2;
        sub    = {{(CH_W-2){1'b0}}, ch[1:0]};
        m.idle = short_map && (ch[1:0] == 2'b00);
        if (short_map)
            m.loc = (grp << 1) + grp + sub - CH_W'(1);
        else
            m.loc = ch;
        return m;
    endfunction
endpackage

// File: rtl/tdm_timebase.sv
module tdm_timebase
    import tdm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            fp_n,
    output logic            run,
    output logic [CH_W-1:0] ch_now,
    output logic [CH_W-1:0] ch_next,
    output logic            load,
    output logic            shift,
    output logic            sample,
    output logic            last
);
    logic             fp_q;
    logic [CYC_W-1:0] cnt;
    logic [CYC_W-1:0] cnt_nx;
    logic             fall;

    assign fall   = fp_q && !fp_n;
    assign cnt_nx = fall ? '0 : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            fp_q <= 1'b1;
            cnt  <= '1;
            run  <= 1'b0;
        end else begin
            fp_q <= fp_n;
            cnt  <= cnt_nx;
            if (fall)
                run <= 1'b1;
        end
    end

    assign ch_now  = cnt[CYC_W-1:SUB_W];
    assign ch_next = cnt_nx[CYC_W-1:SUB_W];
    assign load    = (cnt_nx[SUB_W-1:0] == '0);
    assign shift   = !cnt_nx[0] && !load;
    assign sample  = cnt[0];
    assign last    = run && (cnt[SUB_W-1:0] == '1);

    AST_FRAME_START: assert property (@(posedge clk) disable iff (rst)
        fall |=> (run && ch_now == '0 && cnt[SUB_W-1:0] == '0)); // R2
    AST_CHANNEL_TURN: assert property (@(posedge clk) disable iff (rst)
        last |=> (cnt[SUB_W-1:0] == '0)); // R6
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic         fill_ones,
    input  logic [W-1:0] din,
    output logic         bit_out
);
    logic [W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '1;
        else if (load)
            sh <= fill_ones ? '1 : din;
        else if (shift)
            sh <= {sh[W-2:0], 1'b1};
    end

    assign bit_out = sh[W-1];
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sample,
    input  logic         bit_in,
    output logic [W-1:0] byte_now
);
    logic [W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else if (sample)
            sh <= {sh[W-2:0], bit_in};
    end

    assign byte_now = {sh[W-2:0], bit_in};
endmodule

// File: rtl/tdm_frame_delay.sv
module tdm_frame_delay #(
    parameter int AW = 5,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;
    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                store[i] <= '1;
        end else if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/tdm_serial_port.sv
module tdm_serial_port
    import tdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fp_n,
    input  logic              rxd,
    input  logic [3:0]        cfg,
    input  logic              ch24,
    output logic [CH_W-1:0]   tx_addr,
    input  logic [BYTE_W-1:0] tx0_data,
    input  logic [BYTE_W-1:0] tx1_data,
    output logic              txd0,
    output logic              txd1,
    output logic              rx_we,
    output logic [CH_W-1:0]   rx_addr,
    output logic [BYTE_W-1:0] rx_wdata
);
    logic            run, load, shift, sample, last;
    logic [CH_W-1:0] ch_now, ch_next;
    slot_map_t       map_now, map_next;
    loop_e           lb;
    out1_e           o1;
    logic            t0_bit, t1_bit, dly_bit;
    logic            rx_src, out0, out1;
    logic [BYTE_W-1:0] rx_byte, raw_byte, dly_rd;

    tdm_timebase u_tb (
        .clk(clk), .rst(rst), .fp_n(fp_n), .run(run),
        .ch_now(ch_now), .ch_next(ch_next), .load(load),
        .shift(shift), .sample(sample), .last(last)
    );

    assign map_now  = map_slot(ch_now, ch24);
    assign map_next = map_slot(ch_next, ch24);
    assign lb       = loop_e'(cfg[1:0]);
    assign o1       = out1_e'(cfg[3:2]);
    assign tx_addr  = map_next.loc;

    tdm_tx_lane #(.W(BYTE_W)) u_lane0 (
        .clk(clk), .rst(rst), .load(load), .shift(shift),
        .fill_ones(map_next.idle), .din(tx0_data), .bit_out(t0_bit)
    );
    tdm_tx_lane #(.W(BYTE_W)) u_lane1 (
        .clk(clk), .rst(rst), .load(load), .shift(shift),
        .fill_ones(map_next.idle), .din(tx1_data), .bit_out(t1_bit)
    );
    tdm_tx_lane #(.W(BYTE_W)) u_lane_dly (
        .clk(clk), .rst(rst), .load(load), .shift(shift),
        .fill_ones(1'b0), .din(dly_rd), .bit_out(dly_bit)
    );

    // Receive path source: buffer 0 stream when looped, else the line
    assign rx_src = (lb == LB_TX_TO_RX || lb == LB_CROSS) ? t0_bit : rxd;

    tdm_rx_deser #(.W(BYTE_W)) u_rx (
        .clk(clk), .rst(rst), .sample(sample), .bit_in(rx_src), .byte_now(rx_byte)
    );
    tdm_rx_deser #(.W(BYTE_W)) u_raw (
        .clk(clk), .rst(rst), .sample(sample), .bit_in(rxd), .byte_now(raw_byte)
    );

    tdm_frame_delay #(.AW(CH_W), .W(BYTE_W)) u_dly (
        .clk(clk), .rst(rst), .we(last), .waddr(ch_now), .wdata(raw_byte),
        .raddr(ch_next), .rdata(dly_rd)
    );

    assign rx_we    = last && !map_now.idle;
    assign rx_addr  = map_now.loc;
    assign rx_wdata = rx_byte;

    always_comb begin
        out0 = (lb == LB_IN_TO_OUT || lb == LB_CROSS) ? rxd : t0_bit;
        unique case (o1)
            O1_BUF:     out1 = t1_bit;
            O1_DELAY:   out1 = dly_bit;
            O1_XOR_BUF: out1 = rxd ^ t1_bit;
            default:    out1 = rxd ^ dly_bit;
        endcase
    end

    assign txd0 = run ? out0 : 1'b1;
    assign txd1 = run ? out1 : 1'b1;

    AST_QUIET_BEFORE_SYNC: assert property (@(posedge clk) disable iff (rst)
        !run |-> (txd0 && txd1 && !rx_we)); // R1
    AST_ONE_WRITE_PER_SLOT: assert property (@(posedge clk) disable iff (rst)
        rx_we |=> !rx_we); // R6
    AST_SHORT_MAP_RANGE: assert property (@(posedge clk) disable iff (rst)
        (rx_we && ch24) |-> (rx_addr < CH_W'(24))); // R5
    AST_DIRECT_MAP: assert property (@(posedge clk) disable iff (rst)
        (rx_we && !ch24) |-> (rx_addr == ch_now)); // R3
    AST_IDLE_FILL: assert property (@(posedge clk) disable iff (rst)
        (load && ch24 && ch_next[1:0] == 2'b00) |=> t0_bit); // R4
endmodule

// File: tb/sim_tdm_serial_port.sv
module sim_tdm_serial_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fp_n = 1'b1;
    logic       rxd = 1'b1;
    logic [3:0] cfg = 4'h0;
    logic       ch24 = 1'b0;
    logic [4:0] tx_addr, rx_addr;
    logic [7:0] tx0_data, tx1_data, rx_wdata;
    logic       txd0, txd1, rx_we;
    logic       clr_rx = 1'b0;

    logic [7:0] tx0m [32];
    logic [7:0] tx1m [32];
    logic [7:0] rxm  [32];
    logic [7:0] inb  [32];
    logic [7:0] prev [32];

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign tx0_data = tx0m[tx_addr];
    assign tx1_data = tx1m[tx_addr];

    always @(posedge clk) begin
        if (clr_rx) begin
            for (int i = 0; i < 32; i++) rxm[i] <= 8'h5A;
        end else if (rx_we) begin
            rxm[rx_addr] <= rx_wdata;
        end
    end

    tdm_serial_port u0 (
        .clk(clk), .rst(rst), .fp_n(fp_n), .rxd(rxd), .cfg(cfg), .ch24(ch24),
        .tx_addr(tx_addr), .tx0_data(tx0_data), .tx1_data(tx1_data),
        .txd0(txd0), .txd1(txd1), .rx_we(rx_we), .rx_addr(rx_addr), .rx_wdata(rx_wdata)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int loc_of(input int ch, input bit m24);
        if (!m24) return ch;
        if (ch % 4 == 0) return -1;
        return ch - ch / 4 - 1;
    endfunction

    function automatic logic [7:0] slot_byte(input int ch, input bit m24, input bit which);
        int l;
        l = loc_of(ch, m24);
        if (l < 0) return 8'hFF;
        return which ? tx1m[l] : tx0m[l];
    endfunction

    // Starts a frame with its own pulse and checks both streams and the receive buffer
    task automatic run_frame(input logic [3:0] c, input bit m24, input int seed, input string tag);
        int bad0 = 0, bad1 = 0, badwe = 0, wes = 0, badrx = 0;
        int a0 = 0, e0v = 0, a1 = 0, e1v = 0;
        for (int i = 0; i < 32; i++) begin
            inb[i]  = 8'((i * 53) ^ (seed * 29) ^ (i + seed));
            tx0m[i] = 8'((i * 17 + seed * 7) ^ 8'hC3);
            tx1m[i] = 8'((i * 91 + seed * 13) ^ 8'h3C);
        end
        @(negedge clk);
        cfg = c; ch24 = m24; fp_n = 1'b0; clr_rx = 1'b1;
        for (int k = 0; k < 512; k++) begin
            int ch, bn;
            logic ib, t0b, t1b, db, x0, x1;
            @(negedge clk);
            fp_n = 1'b1; clr_rx = 1'b0;
            ch = k / 16; bn = 7 - (k % 16) / 2;
            ib = inb[ch][bn];
            rxd = ib;
            #1;
            t0b = slot_byte(ch, m24, 1'b0)[bn];
            t1b = slot_byte(ch, m24, 1'b1)[bn];
            db  = prev[ch][bn];
            x0  = c[0] ? ib : t0b;
            case (c[3:2])
                2'b00: x1 = t1b;
                2'b01: x1 = db;
                2'b10: x1 = ib ^ t1b;
                default: x1 = ib ^ db;
            endcase
            if (txd0 !== x0) begin bad0++; a0 = int'(txd0); e0v = int'(x0); end
            if (txd1 !== x1) begin bad1++; a1 = int'(txd1); e1v = int'(x1); end
            if (rx_we === 1'b1) begin
                wes++;
                if (k % 16 != 15) badwe++;
            end
        end
        @(negedge clk);
        for (int l = 0; l < 32; l++) begin
            logic [7:0] ex;
            int ch;
            if (m24 && l >= 24) ex = 8'h5A;
            else begin
                ch = m24 ? (l + l / 3 + 1) : l;
                ex = c[1] ? tx0m[l] : inb[ch];
            end
            if (rxm[l] !== ex) badrx++;
        end
        chk(bad0 == 0, "R2/R3/R4/R7/R11", {tag, " txd0 bit mismatches, last bit"}, a0, e0v);
        if (bad0 != 0) $display("  (%s: %0d bad txd0 bits)", tag, bad0);
        chk(bad1 == 0, "R4/R8/R9/R10", {tag, " txd1 bit mismatches, last bit"}, a1, e1v);
        if (bad1 != 0) $display("  (%s: %0d bad txd1 bits)", tag, bad1);
        chk(badrx == 0, "R3/R5/R6/R7", {tag, " receive buffer bad locations"}, badrx, 0);
        chk(wes == (m24 ? 24 : 32) && badwe == 0, "R5/R6", {tag, " write strobe count"}, wes, m24 ? 24 : 32);
        for (int i = 0; i < 32; i++) prev[i] = inb[i];
    endtask

    task automatic t_reset_and_prestart();
        int bad = 0;
        for (int i = 0; i < 32; i++) prev[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txd0 === 1'b1 && txd1 === 1'b1 && rx_we === 1'b0, "R1", "reset state outputs", {txd0, txd1, rx_we}, 3'b110);
        cfg = 4'b1101;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            rxd = k[1] ^ k[3];
            #1;
            if (txd0 !== 1'b1 || txd1 !== 1'b1 || rx_we !== 1'b0) bad++;
        end
        chk(bad == 0, "R1", "outputs before first frame pulse", bad, 0);
    endtask

    // A pulse mid-frame must restart the count at cycle 0 (R12 folded into R2)
    task automatic t_resync();
        @(negedge clk);
        fp_n = 1'b0;
        @(negedge clk);
        fp_n = 1'b1;
        repeat (99) @(negedge clk);
        run_frame(4'b0000, 1'b0, 9, "R2 resync after mid-frame pulse");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset_and_prestart();
        run_frame(4'b0000, 1'b0, 1, "R3 R8 normal 32-slot");
        run_frame(4'b0101, 1'b0, 2, "R7 R9 input-to-out0 + delayed out1");
        run_frame(4'b1010, 1'b0, 3, "R7 R8 tx0-to-rx + xor buffer1");
        run_frame(4'b1111, 1'b0, 4, "R7 R10 cross loop + xor delayed");
        run_frame(4'b0000, 1'b1, 5, "R4 R5 24-slot normal");
        run_frame(4'b0110, 1'b1, 6, "R5 R9 24-slot tx0-to-rx + delayed");
        t_resync();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule